// File: doc/BRIEF.md
# Thread Interrupt Context Presenter

This block holds the interrupt management state of a single hardware thread. The state is split into four privilege rings: a user ring, an OS ring, a hypervisor pool ring and a physical ring. Each ring keeps an eight-bit pending buffer with one bit per active priority, and a current priority register that masks delivery. A presenter hands the block notifications, each giving a ring and a priority. The block turns each priority into a pending bit, derives the most favoured pending priority, and raises an exception line when that priority is more favoured than the ring's current priority. The OS ring drives an OS exception line. The pool and physical rings together drive a hypervisor exception line. The user ring keeps state but drives no line.

Software reaches the context through a single access port. An access names a view page, a ring and a field. The page sets the privilege of the access: page 0 is hardware, page 1 is hypervisor, page 2 is OS and page 3 is user. A more privileged page sees more rings. Reading the acknowledge field takes the most favoured pending interrupt. A separate per-ring signal-clear input drops a ring's exception line and leaves its state alone.

Top module: `thread_irq_ctx`

## Requirements
- R1: After reset, every ring's pending buffer and current priority are 0x00, both exception outputs are low, and rdValid is low.
- R2: A notification of priority p (0..7) on ring r ORs bit (7-p) into that ring's pending buffer, so priority 0 sets bit 7. A priority above 7 leaves the buffer unchanged.
- R3: A ring's pending priority is 7 minus the index of the highest set bit of its pending buffer. It is 0xFF when the buffer is empty. It is read as field code 2.
- R4: The cycle after an update to a ring (a notification, or a write of its buffer or current priority), the ring's exception flag becomes 1 exactly when its pending priority is numerically lower than its current priority. Ring 1 (OS) drives osIrq. Rings 2 (pool) and 3 (physical) drive hvIrq. Ring 0 (user) drives no output.
- R5: Field code 0 reads and writes the pending buffer, and field code 1 reads and writes the current priority. Writes to field codes 2 and 3 are ignored.
- R6: A read of field code 3 (acknowledge) returns the pending priority. When that priority is not 0xFF, the read also clears its pending bit and loads it into the current priority. In every case the read deasserts the ring's exception flag.
- R7: A signal-clear on ring r deasserts ring r's exception flag on the next cycle and leaves its buffer and current priority unchanged. It takes precedence over an update to the same ring in the same cycle.
- R8: Ring r is visible from page p only when r + p <= 3. An access to a hidden ring writes nothing, returns 0x00 on read, and its acknowledge changes nothing.
- R9: A read sets rdValid and rdData one cycle after the access, with data taken from the state before that cycle's update. A write does not set rdValid. A buffer write and a notification to the same ring in one cycle leave the written value ORed with the notified bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| notifyValid | input | 1 | Notification strobe from the presenter |
| notifyRing | input | 2 | Ring of the notification |
| notifyPrio | input | 8 | Priority of the notification |
| accValid | input | 1 | Register access strobe |
| accWrite | input | 1 | 1 for write, 0 for read |
| accPage | input | 2 | View page of the access (0 hardware .. 3 user) |
| accRing | input | 2 | Ring addressed |
| accField | input | 2 | Field code: 0 buffer, 1 current priority, 2 pending priority, 3 acknowledge |
| accWdata | input | 8 | Write data |
| sigValid | input | 1 | Signal-clear strobe |
| sigRing | input | 2 | Ring whose exception flag is cleared |
| rdValid | output | 1 | Read data valid |
| rdData | output | 8 | Read data |
| osIrq | output | 1 | OS exception line |
| hvIrq | output | 1 | Hypervisor exception line |

## Verification
The notification path is swept over priorities 0 to 9 and 0xFF on every ring. This separates the bit mapping from the out-of-range case. A grid of current priority 0..8 against pending priority 0..7 on each output-driving ring checks the strict comparison at its boundary and checks which line each ring drives. A chain of three notifications followed by repeated acknowledges checks the ordering of the pending buffer and the empty result 0xFF. A sweep over all page and ring pairs distinguishes visible accesses from hidden ones for writes, reads and acknowledges. Same-cycle cases cover write plus notify and signal-clear plus notify.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int RING_CNT   = 4;
  localparam int RING_IDX_W = $clog2(RING_CNT);
  localparam int PRIO_W     = 8;
  localparam int ACTIVE_CNT = 8;
  localparam int OS_RING    = 1;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef enum logic [1:0] {
    FLD_IPB  = 2'd0,
    FLD_CPPR = 2'd1,
    FLD_PIPR = 2'd2,
    FLD_ACK  = 2'd3
  } fieldT;

  typedef struct packed {
    logic [RING_CNT-1:0]   wrIpb;
    logic [RING_CNT-1:0]   wrCppr;
    logic [RING_CNT-1:0]   ack;
    logic [RING_CNT-1:0]   sigClr;
    logic [RING_CNT-1:0]   notify;
    logic [PRIO_W-1:0]     notifyBit;
    logic [PRIO_W-1:0]     wrData;
    logic                  rdEn;
    logic                  rdVisible;
    logic [RING_IDX_W-1:0] rdRing;
    fieldT                 rdField;
  } strobeT;

  // Priority to pending-buffer bit: priority 0 is the top bit.
  function automatic logic [PRIO_W-1:0] prioToBit(input logic [PRIO_W-1:0] prio);
    logic [PRIO_W-1:0] res;
    res = '0;
    for (int i = 0; i < ACTIVE_CNT; i++) begin
      if (prio == PRIO_W'(i)) res[ACTIVE_CNT-1-i] = 1'b1;
    end
    return res;
  endfunction

  // Most favoured pending priority, or PRIO_NONE when empty.
  function automatic logic [PRIO_W-1:0] bitsToPrio(input logic [PRIO_W-1:0] ipb);
    logic [PRIO_W-1:0] res;
    res = PRIO_NONE;
    for (int i = 0; i < ACTIVE_CNT; i++) begin
      if (ipb[i]) res = PRIO_W'(ACTIVE_CNT - 1 - i);
    end
    return res;
  endfunction
endpackage

// File: rtl/tctx_ctrl.sv
module tctx_ctrl
  import tctx_pkg::*;
(
  input  logic                  notifyValid,
  input  logic [RING_IDX_W-1:0] notifyRing,
  input  logic [PRIO_W-1:0]     notifyPrio,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic [RING_IDX_W-1:0] accPage,
  input  logic [RING_IDX_W-1:0] accRing,
  input  logic [1:0]            accField,
  input  logic [PRIO_W-1:0]     accWdata,
  input  logic                  sigValid,
  input  logic [RING_IDX_W-1:0] sigRing,
  output strobeT                st
);
  localparam int SUM_W = RING_IDX_W + 1;
  localparam logic [SUM_W-1:0] TOP_RING = SUM_W'(RING_CNT - 1);

  logic  visible;
  fieldT field;
  logic  wrAcc;
  logic  rdAcc;

  assign visible = ({1'b0, accRing} + {1'b0, accPage}) <= TOP_RING;
  assign field   = fieldT'(accField);
  assign wrAcc   = accValid && accWrite && visible;
  assign rdAcc   = accValid && !accWrite;

  for (genvar r = 0; r < RING_CNT; r++) begin : g_ring
    logic hitRing;
    assign hitRing        = (accRing == RING_IDX_W'(r));
    assign st.wrIpb[r]    = wrAcc && hitRing && (field == FLD_IPB);
    assign st.wrCppr[r]   = wrAcc && hitRing && (field == FLD_CPPR);
    assign st.ack[r]      = rdAcc && visible && hitRing && (field == FLD_ACK);
    assign st.sigClr[r]   = sigValid && (sigRing == RING_IDX_W'(r));
    assign st.notify[r]   = notifyValid && (notifyRing == RING_IDX_W'(r));
  end

  assign st.notifyBit = prioToBit(notifyPrio);
  assign st.wrData    = accWdata;
  assign st.rdEn      = rdAcc;
  assign st.rdVisible = visible;
  assign st.rdRing    = accRing;
  assign st.rdField   = field;
endmodule

// File: rtl/tctx_datapath.sv
module tctx_datapath
  import tctx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                st,
  output logic                  rdValid,
  output logic [PRIO_W-1:0]     rdData,
  output logic [RING_CNT-1:1]   ringIrq
);
  logic [RING_CNT-1:0][PRIO_W-1:0] ipbAll;
  logic [RING_CNT-1:0][PRIO_W-1:0] cpprAll;
  logic [RING_CNT-1:0][PRIO_W-1:0] piprAll;

  for (genvar r = 0; r < RING_CNT; r++) begin : g_ring
    logic [PRIO_W-1:0] ipbQ, cpprQ, pipr;
    logic [PRIO_W-1:0] ipbMid, ipbNext, cpprNext;
    logic              ackHit, touched;

    assign pipr    = bitsToPrio(ipbQ);
    assign ackHit  = st.ack[r] && (pipr != PRIO_NONE);
    assign touched = st.wrIpb[r] || st.wrCppr[r] || st.ack[r] || st.notify[r];

    always_comb begin
      ipbMid = st.wrIpb[r] ? st.wrData : ipbQ;
      if (ackHit) ipbMid = ipbMid & ~prioToBit(pipr);
      ipbNext = ipbMid | (st.notify[r] ? st.notifyBit : '0);
      if (st.wrCppr[r])  cpprNext = st.wrData;
      else if (ackHit)   cpprNext = pipr;
      else               cpprNext = cpprQ;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ipbQ  <= '0;
        cpprQ <= '0;
      end else if (touched) begin
        ipbQ  <= ipbNext;
        cpprQ <= cpprNext;
      end
    end

    if (r > 0) begin : g_exc
      logic excQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        excQ <= 1'b0;
        else if (st.sigClr[r] || st.ack[r]) excQ <= 1'b0;
        else if (touched)                 excQ <= (bitsToPrio(ipbNext) < cpprNext);
      end
      assign ringIrq[r] = excQ;
    end

    assign ipbAll[r]  = ipbQ;
    assign cpprAll[r] = cpprQ;
    assign piprAll[r] = pipr;
  end

  logic [PRIO_W-1:0] rdMux;
  always_comb begin
    rdMux = '0;
    if (st.rdVisible) begin
      unique case (st.rdField)
        FLD_IPB:  rdMux = ipbAll[st.rdRing];
        FLD_CPPR: rdMux = cpprAll[st.rdRing];
        FLD_PIPR: rdMux = piprAll[st.rdRing];
        FLD_ACK:  rdMux = piprAll[st.rdRing];
        default:  rdMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= st.rdEn;
      if (st.rdEn) rdData <= rdMux;
    end
  end
endmodule

// File: rtl/thread_irq_ctx.sv
module thread_irq_ctx
  import tctx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  notifyValid,
  input  logic [RING_IDX_W-1:0] notifyRing,
  input  logic [PRIO_W-1:0]     notifyPrio,
  input  logic                  accValid,
  input  logic                  accWrite,
  input  logic [RING_IDX_W-1:0] accPage,
  input  logic [RING_IDX_W-1:0] accRing,
  input  logic [1:0]            accField,
  input  logic [PRIO_W-1:0]     accWdata,
  input  logic                  sigValid,
  input  logic [RING_IDX_W-1:0] sigRing,
  output logic                  rdValid,
  output logic [PRIO_W-1:0]     rdData,
  output logic                  osIrq,
  output logic                  hvIrq
);
  strobeT              st;
  logic [RING_CNT-1:1] ringIrq;

  tctx_ctrl u_ctrl (
    .notifyValid(notifyValid), .notifyRing(notifyRing), .notifyPrio(notifyPrio),
    .accValid(accValid), .accWrite(accWrite), .accPage(accPage),
    .accRing(accRing), .accField(accField), .accWdata(accWdata),
    .sigValid(sigValid), .sigRing(sigRing), .st(st)
  );

  tctx_datapath u_dp (
    .clk(clk), .rstN(rstN), .st(st),
    .rdValid(rdValid), .rdData(rdData), .ringIrq(ringIrq)
  );

  assign osIrq = ringIrq[OS_RING];
  assign hvIrq = |ringIrq[RING_CNT-1:OS_RING+1];
endmodule

// File: rtl/thread_irq_ctx_chk.sv
module thread_irq_ctx_chk
  import tctx_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  notifyValid,
  input logic [RING_IDX_W-1:0] notifyRing,
  input logic [PRIO_W-1:0]     notifyPrio,
  input logic                  accValid,
  input logic                  accWrite,
  input logic [RING_IDX_W-1:0] accPage,
  input logic [RING_IDX_W-1:0] accRing,
  input logic [1:0]            accField,
  input logic [PRIO_W-1:0]     accWdata,
  input logic                  sigValid,
  input logic [RING_IDX_W-1:0] sigRing,
  input logic                  rdValid,
  input logic [PRIO_W-1:0]     rdData,
  input logic                  osIrq,
  input logic                  hvIrq
);
  logic rdReq, hidden, osAck;
  assign rdReq  = accValid && !accWrite;
  assign hidden = ({1'b0, accRing} + {1'b0, accPage}) > (RING_IDX_W+1)'(RING_CNT - 1);
  assign osAck  = rdReq && !hidden && accField == 2'd3 && accRing == RING_IDX_W'(OS_RING);

  // R9
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq |=> rdValid);
  // R9
  no_spurious_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);
  // R8
  hidden_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && hidden) |=> (rdData == '0));
  // R7
  sig_clear_os_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sigValid && sigRing == RING_IDX_W'(OS_RING)) |=> !osIrq);
  // R6
  ack_clear_os_chk: assert property (@(posedge clk) disable iff (!rstN)
    osAck |=> !osIrq);
  // R6
  ack_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !hidden && accField == 2'd3) |=> (rdData < PRIO_W'(ACTIVE_CNT) || rdData == PRIO_NONE));
  // R4
  os_rise_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(osIrq) |-> $past((notifyValid && notifyRing == RING_IDX_W'(OS_RING)) ||
                           (accValid && accWrite && accRing == RING_IDX_W'(OS_RING))));
endmodule

bind thread_irq_ctx thread_irq_ctx_chk u_chk (.*);

// File: tb/thread_irq_ctx_test.sv
`timescale 1ns/1ps
module thread_irq_ctx_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       notifyValid;
  logic [1:0] notifyRing;
  logic [7:0] notifyPrio;
  logic       accValid, accWrite;
  logic [1:0] accPage, accRing, accField;
  logic [7:0] accWdata;
  logic       sigValid;
  logic [1:0] sigRing;
  logic       rdValid;
  logic [7:0] rdData;
  logic       osIrq, hvIrq;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [7:0] mIpb [4];
  logic [7:0] mCppr [4];
  logic       mExc [4];

  always #2.5 clk = ~clk;

  thread_irq_ctx uut (
    .clk(clk), .rstN(rstN), .notifyValid(notifyValid), .notifyRing(notifyRing),
    .notifyPrio(notifyPrio), .accValid(accValid), .accWrite(accWrite),
    .accPage(accPage), .accRing(accRing), .accField(accField), .accWdata(accWdata),
    .sigValid(sigValid), .sigRing(sigRing), .rdValid(rdValid), .rdData(rdData),
    .osIrq(osIrq), .hvIrq(hvIrq)
  );

  function automatic logic [7:0] bitOf(input int p);
    return (p > 7 || p < 0) ? 8'h00 : (8'h80 >> p);
  endfunction

  function automatic logic [7:0] piprOf(input logic [7:0] v);
    for (int p = 0; p < 8; p++) if (v[7-p]) return 8'(p);
    return 8'hFF;
  endfunction

  function automatic bit seen(input int page, input int ring);
    return (page + ring) <= 3;
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic checkIrq(input string tag);
    check({tag, " osIrq"}, {7'd0, osIrq}, {7'd0, mExc[1]});
    check({tag, " hvIrq"}, {7'd0, hvIrq}, {7'd0, mExc[2] | mExc[3]});
  endtask

  task automatic idle();
    notifyValid = 0; notifyRing = 0; notifyPrio = 0;
    accValid = 0; accWrite = 0; accPage = 0; accRing = 0; accField = 0; accWdata = 0;
    sigValid = 0; sigRing = 0;
  endtask

  task automatic recalc(input int r);
    if (r > 0) mExc[r] = (piprOf(mIpb[r]) < mCppr[r]);
  endtask

  task automatic doNotify(input int r, input int p, input string tag);
    @(negedge clk);
    notifyValid = 1; notifyRing = 2'(r); notifyPrio = 8'(p);
    mIpb[r] = mIpb[r] | bitOf(p);
    recalc(r);
    @(negedge clk);
    idle();
    checkIrq(tag);
  endtask

  task automatic doSig(input int r, input string tag);
    @(negedge clk);
    sigValid = 1; sigRing = 2'(r);
    mExc[r] = 0;
    @(negedge clk);
    idle();
    checkIrq(tag);
  endtask

  task automatic doWrite(input int pg, input int r, input int f, input logic [7:0] d, input string tag);
    @(negedge clk);
    accValid = 1; accWrite = 1; accPage = 2'(pg); accRing = 2'(r); accField = 2'(f); accWdata = d;
    if (seen(pg, r) && f < 2) begin
      if (f == 0) mIpb[r] = d; else mCppr[r] = d;
      recalc(r);
    end
    @(negedge clk);
    idle();
    check({tag, " rdValid after write"}, {7'd0, rdValid}, 8'd0);
    checkIrq(tag);
  endtask

  task automatic doRead(input int pg, input int r, input int f, input string tag);
    logic [7:0] exp;
    @(negedge clk);
    accValid = 1; accWrite = 0; accPage = 2'(pg); accRing = 2'(r); accField = 2'(f);
    if (!seen(pg, r)) exp = 8'h00;
    else if (f == 0) exp = mIpb[r];
    else if (f == 1) exp = mCppr[r];
    else exp = piprOf(mIpb[r]);
    if (f == 3 && seen(pg, r)) begin
      if (exp != 8'hFF) begin
        mIpb[r] = mIpb[r] & ~bitOf(int'(exp));
        mCppr[r] = exp;
      end
      mExc[r] = 0;
    end
    @(negedge clk);
    idle();
    check({tag, " rdValid"}, {7'd0, rdValid}, 8'd1);
    check({tag, " rdData"}, rdData, exp);
    checkIrq(tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 0;
    for (int r = 0; r < 4; r++) begin mIpb[r] = 0; mCppr[r] = 0; mExc[r] = 0; end
    repeat (3) @(negedge clk);
    // R1 reset state at the ports
    check("R1 rdValid", {7'd0, rdValid}, 8'd0);
    checkIrq("R1");
    rstN = 1;
    for (int r = 0; r < 4; r++) begin
      doRead(0, r, 0, "R1 ipb");
      doRead(0, r, 1, "R1 cppr");
    end

    // R2 / R3: priority mapping on every ring, CPPR 0 keeps lines low
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 11; p++) begin
        int prio;
        prio = (p == 10) ? 255 : p;
        doWrite(0, r, 0, 8'h00, "R5 clear");
        doNotify(r, prio, "R2 notify");
        doRead(0, r, 0, "R2 ipb");
        doRead(0, r, 2, "R3 pipr");
      end
      doWrite(0, r, 0, 8'h00, "R5 clear");
    end

    // R4 / R7: comparison grid and signal clear
    for (int r = 1; r < 4; r++) begin
      for (int c = 0; c < 9; c++) begin
        for (int p = 0; p < 8; p++) begin
          doWrite(0, r, 0, 8'h00, "R4 clear");
          doWrite(0, r, 1, 8'(c), "R4 cppr");
          doNotify(r, p, "R4 compare");
          doSig(r, "R7 sigclr");
          doRead(0, r, 0, "R7 ipb kept");
        end
      end
      doWrite(0, r, 0, 8'h00, "R4 clear");
      doWrite(0, r, 1, 8'h00, "R4 clear");
    end

    // R6: acknowledge order on the OS ring
    doWrite(0, 1, 1, 8'hFF, "R6 open");
    doNotify(1, 5, "R6 n5");
    doNotify(1, 2, "R6 n2");
    doNotify(1, 6, "R6 n6");
    doRead(0, 1, 0, "R6 ipb");
    check("R6 ipb value", mIpb[1], 8'h26);
    for (int k = 0; k < 4; k++) begin
      doRead(0, 1, 3, "R6 ack");
      doRead(0, 1, 1, "R6 cppr");
    end
    doRead(2, 1, 3, "R6 ack empty");

    // R5: read-only fields ignore writes
    doWrite(0, 0, 0, 8'h01, "R5 ipb");
    doWrite(0, 0, 2, 8'h00, "R5 pipr wr");
    doWrite(0, 0, 3, 8'h00, "R5 ack wr");
    doRead(0, 0, 2, "R5 pipr");
    doRead(0, 0, 0, "R5 ipb kept");

    // R8: visibility sweep
    for (int pg = 0; pg < 4; pg++) begin
      for (int r = 0; r < 4; r++) begin
        doWrite(0, r, 1, 8'h00, "R8 cppr");
        doWrite(0, r, 0, 8'h11, "R8 seed");
        doWrite(pg, r, 0, 8'hAA, "R8 write");
        doRead(0, r, 0, "R8 readback");
        doRead(pg, r, 0, "R8 view");
        doRead(pg, r, 3, "R8 ack");
        doRead(0, r, 0, "R8 after ack");
        doRead(0, r, 1, "R8 cppr after ack");
      end
    end

    // R9: write and notify in one cycle
    doWrite(0, 2, 1, 8'hFF, "R9 cppr");
    @(negedge clk);
    accValid = 1; accWrite = 1; accPage = 0; accRing = 2; accField = 0; accWdata = 8'h01;
    notifyValid = 1; notifyRing = 2; notifyPrio = 1;
    mIpb[2] = 8'h41; recalc(2);
    @(negedge clk);
    idle();
    checkIrq("R9 merge");
    doRead(0, 2, 0, "R9 merged ipb");

    // R7: signal clear beats a same-cycle notify
    doRead(0, 2, 3, "R7 drain");
    doWrite(0, 2, 1, 8'hFF, "R7 cppr");
    @(negedge clk);
    sigValid = 1; sigRing = 2; notifyValid = 1; notifyRing = 2; notifyPrio = 3;
    mIpb[2] = mIpb[2] | bitOf(3); mExc[2] = 0;
    @(negedge clk);
    idle();
    checkIrq("R7 precedence");
    doRead(0, 2, 0, "R7 ipb updated");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule